// File: doc/BRIEF.md
# Configuration Header Register File with Base Address Sizing

This block is the target-side register file for the 64-byte standard header of a peripheral's configuration space. Software reaches it through a plain register port. Each request carries a dword index, a read/write flag, four byte enables and a write data word. Reads return one dword on a registered response port. Index 0 returns a fixed identity word, made of the device and vendor codes, which writes cannot change.

Dword indices 4 through 9 hold six base address registers (BARs). Each BAR is set at build time to one of three kinds: absent, I/O or memory. Each also has a window size given as a power of two. Only the bits at or above log2 of the size can be written, and the low bits carry fixed type and attribute values. Software sizes a window by writing all ones to a BAR and reading it back. After that probe it writes the assigned base address into the same BAR.

Top module: `cfg_header_regs`

## Requirements
- R1: A read of dword index 0 returns the parameter ID_WORD (device code in bits 31:16, vendor code in bits 15:0). Writes to index 0 leave it unchanged.
- R2: A read request accepted on one clock edge raises rsp_valid for exactly the following cycle, with rsp_rdata valid in that cycle. Write requests produce no response, and rsp_valid is low during reset.
- R3: In an implemented BAR only bits at or above log2(size) are writable, and bits below that position read as zero apart from the fixed low bits. A 64 KiB memory BAR reads FFFF0000h after an all-ones write.
- R4: A memory BAR always reads 0 in bit 0, and bits 3:1 always read its configured 3-bit attribute value.
- R5: An I/O BAR always reads 01b in bits 1:0.
- R6: After reset every writable BAR bit is zero, so each BAR reads only its fixed low bits.
- R7: A write changes only the byte lanes whose enable bit is set (req_be[n] covers bits 8n+7:8n). Lanes that are not enabled keep their previous contents.
- R8: Indices 1–3 and 10–15 read as zero, and writes to them change no register.
- R9: A BAR configured as absent reads as zero and ignores every write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | 4 | Dword index inside the 64-byte header |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |

## Verification
Every read result is due exactly one cycle after the edge that accepts the request. A write becomes visible to a read issued on the very next cycle. The bench puts the expected word and its due cycle into a queue when it drives each read. A monitor that samples on the falling edge pops an entry at each response and compares both the data and the arrival cycle. Any response with nothing queued counts as a latency failure, and so does any entry left in the queue at the end.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    localparam int DATA_W     = 32;
    localparam int LANES      = DATA_W / 8;
    localparam int IDX_W      = 4;
    localparam int NUM_BARS   = 6;
    localparam int BAR_FIRST  = 4;
    localparam int KIND_W     = 2;
    localparam int LOG2_W     = 5;
    localparam int ATTR_W     = 3;
    localparam int IO_MIN_LG  = 2;
    localparam int MEM_MIN_LG = 4;

    typedef enum logic [KIND_W-1:0] {
        SLOT_ABSENT = 2'd0,
        SLOT_IO     = 2'd1,
        SLOT_MEM    = 2'd2
    } slot_kind_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [IDX_W-1:0]  idx;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] data;
    } cfg_req_t;

    // Writable-bit mask: all bits at or above the effective size exponent.
    function automatic logic [DATA_W-1:0] keep_mask(slot_kind_e kind, int unsigned lg);
        int unsigned eff;
        logic [DATA_W-1:0] m;
        if (kind == SLOT_ABSENT) begin
            m = '0;
        end else begin
            eff = lg;
            if (kind == SLOT_IO && eff < IO_MIN_LG)   eff = IO_MIN_LG;
            if (kind == SLOT_MEM && eff < MEM_MIN_LG) eff = MEM_MIN_LG;
            m = '1 << eff;
        end
        return m;
    endfunction

    // Hard-wired low bits of a BAR.
    function automatic logic [DATA_W-1:0] fixed_low(slot_kind_e kind, logic [ATTR_W-1:0] attr);
        logic [DATA_W-1:0] f;
        case (kind)
            SLOT_IO:  f = {{(DATA_W-2){1'b0}}, 2'b01};
            SLOT_MEM: f = {{(DATA_W-ATTR_W-1){1'b0}}, attr, 1'b0};
            default:  f = '0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
    import cfg_hdr_pkg::*;
#(
    parameter slot_kind_e        KIND = SLOT_MEM,
    parameter int unsigned       LG   = 16,
    parameter logic [ATTR_W-1:0] ATTR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_val
);

    localparam logic [DATA_W-1:0] WMASK = keep_mask(KIND, LG);
    localparam logic [DATA_W-1:0] FIXED = fixed_low(KIND, ATTR);

    logic [DATA_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (wr_en) begin
            for (int l = 0; l < LANES; l++) begin
                if (be[l]) base_q[8*l +: 8] <= wdata[8*l +: 8] & WMASK[8*l +: 8];
            end
        end
    end

    assign rd_val = base_q | FIXED;

    // R3
    low_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_val & ~WMASK) == FIXED);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(base_q));

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        // R7
        lane_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && !be[l]) |=> $stable(base_q[8*l +: 8]));
    end

    if (KIND == SLOT_IO) begin : g_io_chk
        // R5
        io_tag_chk: assert property (@(posedge clk) disable iff (rst)
            rd_val[1:0] == 2'b01);
    end else if (KIND == SLOT_MEM) begin : g_mem_chk
        // R4
        mem_tag_chk: assert property (@(posedge clk) disable iff (rst)
            rd_val[3:0] == {ATTR, 1'b0});
    end else begin : g_absent_chk
        // R9
        absent_zero_chk: assert property (@(posedge clk) disable iff (rst)
            rd_val == '0);
    end

endmodule

// File: rtl/cfg_wr_decode.sv
module cfg_wr_decode
    import cfg_hdr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  cfg_req_t            req,
    output logic [NUM_BARS-1:0] bar_wr
);

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_sel
        assign bar_wr[g] = req.valid && req.write && (req.idx == IDX_W'(BAR_FIRST + g));
    end

    // R8
    wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bar_wr));

    // R8
    hole_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.write && (req.idx < IDX_W'(BAR_FIRST)
         || req.idx >= IDX_W'(BAR_FIRST + NUM_BARS))) |-> bar_wr == '0);

endmodule

// File: rtl/cfg_rd_port.sv
module cfg_rd_port
    import cfg_hdr_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_WORD = 32'h0
) (
    input  logic              clk,
    input  logic              rst,
    input  cfg_req_t          req,
    input  logic [DATA_W-1:0] bar_vals [NUM_BARS],
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic [DATA_W-1:0] sel_val;
    logic              rd_go;

    assign rd_go = req.valid && !req.write;

    always_comb begin
        sel_val = '0;
        if (req.idx == '0) sel_val = ID_WORD;
        for (int b = 0; b < NUM_BARS; b++) begin
            if (req.idx == IDX_W'(BAR_FIRST + b)) sel_val = bar_vals[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_go;
            if (rd_go) rsp_rdata <= sel_val;
        end
    end

    // R2
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        rd_go |=> rsp_valid);

    // R2
    rsp_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_go |=> !rsp_valid);

    // R1
    id_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_go && req.idx == '0) |=> rsp_rdata == ID_WORD);

    // R8
    hole_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_go && req.idx != '0 && (req.idx < IDX_W'(BAR_FIRST)
         || req.idx >= IDX_W'(BAR_FIRST + NUM_BARS))) |=> rsp_rdata == '0);

endmodule

// File: rtl/cfg_header_regs.sv
module cfg_header_regs
    import cfg_hdr_pkg::*;
#(
    parameter logic [DATA_W-1:0]          ID_WORD   = 32'h5A3C_1E0F,
    parameter logic [NUM_BARS*KIND_W-1:0] BAR_KINDS = 12'h926,
    parameter logic [NUM_BARS*LOG2_W-1:0] BAR_LOG2  = {5'd20, 5'd4, 5'd0, 5'd12, 5'd8, 5'd16},
    parameter logic [NUM_BARS*ATTR_W-1:0] BAR_ATTR  = {3'd0, 3'd0, 3'd0, 3'd4, 3'd0, 3'd0}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [3:0]        req_idx,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata
);

    cfg_req_t            req;
    logic [NUM_BARS-1:0] bar_wr;
    logic [DATA_W-1:0]   bar_vals [NUM_BARS];

    assign req = '{valid: req_valid, write: req_write, idx: req_idx,
                   be: req_be, data: req_wdata};

    cfg_wr_decode u_dec (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .bar_wr (bar_wr)
    );

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
        cfg_bar_slot #(
            .KIND (slot_kind_e'(BAR_KINDS[KIND_W*g +: KIND_W])),
            .LG   (int'(BAR_LOG2[LOG2_W*g +: LOG2_W])),
            .ATTR (BAR_ATTR[ATTR_W*g +: ATTR_W])
        ) u_slot (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (bar_wr[g]),
            .be     (req.be),
            .wdata  (req.data),
            .rd_val (bar_vals[g])
        );
    end

    cfg_rd_port #(.ID_WORD(ID_WORD)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .bar_vals  (bar_vals),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: tb/sim_cfg_header_regs.sv
module sim_cfg_header_regs;

    localparam logic [31:0] ID = 32'h5A3C_1E0F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_idx = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int cyc = 0;
    int errors = 0;
    int checks = 0;

    typedef struct {
        logic [31:0] d;
        string       tag;
        int          due;
    } exp_t;

    exp_t sb[$];

    cfg_header_regs u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_idx(req_idx), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic rd(input logic [3:0] i, input logic [31:0] e, input string tag);
        exp_t x;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_idx = i; req_be = 4'h0; req_wdata = '0;
        x.d = e; x.tag = tag; x.due = cyc + 1;
        sb.push_back(x);
    endtask

    task automatic wr(input logic [3:0] i, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_idx = i; req_be = be; req_wdata = d;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Monitor: pops one expectation per response, checks data and arrival cycle.
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected response: actual data %08h, expected none", rsp_rdata);
            end else begin
                exp_t x;
                x = sb.pop_front();
                if (cyc != x.due) begin
                    errors++;
                    $display("FAIL R2 response cycle: actual %0d expected %0d", cyc, x.due);
                end
                if (rsp_rdata !== x.d) begin
                    errors++;
                    $display("FAIL %s read data: actual %08h expected %08h", x.tag, rsp_rdata, x.d);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R2 watchdog expired: actual %0d cycles expected fewer", cyc);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2 reset rsp_valid: actual %b expected 0", rsp_valid);
        end
        rst = 1'b0;

        // R1 identity
        rd(4'd0, ID, "R1");
        // R6 reset values (R9 for absent slot at index 7)
        rd(4'd4, 32'h0000_0000, "R6");
        rd(4'd5, 32'h0000_0001, "R6");
        rd(4'd6, 32'h0000_0008, "R6");
        rd(4'd7, 32'h0000_0000, "R9");
        rd(4'd8, 32'h0000_0001, "R6");
        rd(4'd9, 32'h0000_0000, "R6");
        idle();

        // Sizing probe
        for (int i = 4; i <= 9; i++) wr(4'(i), 32'hFFFF_FFFF, 4'hF);
        rd(4'd4, 32'hFFFF_0000, "R3");
        rd(4'd5, 32'hFFFF_FF01, "R5");
        rd(4'd6, 32'hFFFF_F008, "R4");
        rd(4'd7, 32'h0000_0000, "R9");
        rd(4'd8, 32'hFFFF_FFF1, "R5");
        rd(4'd9, 32'hFFF0_0000, "R3");
        idle();

        // R1 identity is read-only
        wr(4'd0, 32'h0000_0000, 4'hF);
        rd(4'd0, ID, "R1");

        // R8 holes
        wr(4'd1, 32'hFFFF_FFFF, 4'hF);
        wr(4'd15, 32'hFFFF_FFFF, 4'hF);
        rd(4'd1, 32'h0, "R8");
        rd(4'd15, 32'h0, "R8");
        rd(4'd2, 32'h0, "R8");
        rd(4'd4, 32'hFFFF_0000, "R8");
        idle();

        // R7 byte enables
        wr(4'd4, 32'h7712_7777, 4'b0100);
        rd(4'd4, 32'hFF12_0000, "R7");
        wr(4'd9, 32'h0000_0000, 4'b1000);
        rd(4'd9, 32'h00F0_0000, "R7");
        wr(4'd5, 32'h0000_0000, 4'b0000);
        rd(4'd5, 32'hFFFF_FF01, "R7");

        // R3 base assignment
        wr(4'd4, 32'hABCD_1234, 4'hF);
        rd(4'd4, 32'hABCD_0000, "R3");
        wr(4'd6, 32'h1234_5678, 4'hF);
        rd(4'd6, 32'h1234_5008, "R4");
        idle();
        repeat (3) idle();

        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R2 missing responses: actual %0d pending expected 0", sb.size());
        end
        finish_run();
    end

endmodule